// File: doc/BRIEF.md
# Lost Frame Counter with Wrap Interrupt

This block tallies receive frames that were thrown away because the receive buffer was in overflow. A frame is counted only if the address filter accepted it and it finished without a collision. The address filter, the collision detector and the overflow condition are inputs from neighbouring logic. The host reads the running 8-bit tally directly.

Each time the tally rolls over from its top value to zero, a sticky wrap flag is set. The interrupt output follows that flag unless the host masks it. Reading the status location clears the flag. After a hardware or software reset, counting stays disabled until the receiver has been enabled at least once. A sticky arm bit records that first enable.

Top module: `lost_frame_counter`

## Requirements
- R1: After hardware reset (rst_ni low), count_o is 0, wrap_flag_o is 0 and irq_o is 0.
- R2: When frame_end_i, addr_match_i and rx_overflow_i are high, collision_i is low, and the block is armed, count_o is one higher after the next rising clock edge.
- R3: A frame_end_i pulse with addr_match_i low, collision_i high, or rx_overflow_i low leaves count_o unchanged.
- R4: After any reset, frames are not counted until rx_enable_i has been high for at least one cycle. A frame in that same cycle counts. Once armed, the block keeps counting after rx_enable_i drops.
- R5: A counted frame at count_o = 255 makes count_o 0 and sets wrap_flag_o after the edge. Counting then continues from 0.
- R6: irq_o is high exactly when wrap_flag_o is high and irq_mask_i is low.
- R7: A stat_rd_i pulse clears wrap_flag_o at the next edge. If a wrap happens in the same cycle, the flag is set.
- R8: A soft_rst_i pulse clears count_o, wrap_flag_o and the arm bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset pulse |
| rx_enable_i | input | 1 | Receiver enable level |
| frame_end_i | input | 1 | Single-cycle end-of-frame strobe |
| addr_match_i | input | 1 | Frame passed the address filter |
| collision_i | input | 1 | Frame saw a collision |
| rx_overflow_i | input | 1 | Receive buffer is in overflow |
| stat_rd_i | input | 1 | Status read strobe; clears the wrap flag |
| irq_mask_i | input | 1 | Suppresses irq_o when high |
| count_o | output | 8 | Lost frame tally |
| wrap_flag_o | output | 1 | Sticky wrap status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends qualified frames both before the first enable and after the enable has dropped. A design whose arm bit is not sticky, or that counts before arming, drifts from the expected tally. It removes each qualifier in turn, which exposes a missing term in the frame qualification. It drives the tally through two full wraps, the second with a status read in the same cycle as the wrap. This catches a clear that overrides a set, and a flag raised one count early or late. It ends with a software reset followed by frames, to show that the arm bit is cleared along with the tally.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned CNT_W_DEF = 8;

  typedef struct packed {
    logic fin;
    logic match;
    logic coll;
    logic ovf;
  } frame_ev_t;
endpackage

// File: rtl/lfc_arm.sv
module lfc_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_clr_i,
  input  logic en_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (soft_clr_i) armed_q <= 1'b0;
    else if (en_i)       armed_q <= 1'b1;
  end

  // a frame in the enabling cycle already counts
  assign armed_o = armed_q | en_i;

  p_arm_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !soft_clr_i |=> armed_q);
  p_arm_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> !armed_q);
endmodule

// File: rtl/lfc_qual.sv
module lfc_qual
  import lfc_pkg::*;
(
  input  frame_ev_t ev_i,
  input  logic      armed_i,
  output logic      inc_o
);
  always_comb begin
    inc_o = ev_i.fin & ev_i.match & ~ev_i.coll & ev_i.ovf & armed_i;
  end
endmodule

// File: rtl/lfc_count.sv
module lfc_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_TOP = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (soft_clr_i) cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & (cnt_q == CNT_TOP);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !soft_clr_i |=> cnt_q == $past(cnt_q) + CNT_ONE);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !soft_clr_i |=> $stable(cnt_q));
  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !soft_clr_i |=> cnt_q == '0);
endmodule

// File: rtl/lfc_flag.sv
module lfc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_clr_i,
  input  logic wrap_i,
  input  logic rd_clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (soft_clr_i) flag_q <= 1'b0;
    else if (wrap_i)     flag_q <= 1'b1;  // set wins over read clear
    else if (rd_clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_i;

  p_wrap_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i && !soft_clr_i |=> flag_q);
  p_rd_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && !wrap_i |=> !flag_q);
  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !irq_o);
endmodule

// File: rtl/lost_frame_counter.sv
module lost_frame_counter
  import lfc_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             rx_enable_i,
  input  logic             frame_end_i,
  input  logic             addr_match_i,
  input  logic             collision_i,
  input  logic             rx_overflow_i,
  input  logic             stat_rd_i,
  input  logic             irq_mask_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_flag_o,
  output logic             irq_o
);
  frame_ev_t ev;
  logic      armed;
  logic      inc;
  logic      wrap;

  assign ev = '{fin: frame_end_i, match: addr_match_i,
                coll: collision_i, ovf: rx_overflow_i};

  lfc_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_rst_i),
    .en_i       (rx_enable_i),
    .armed_o    (armed)
  );

  lfc_qual u_qual (
    .ev_i    (ev),
    .armed_i (armed),
    .inc_o   (inc)
  );

  lfc_count #(.W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_rst_i),
    .inc_i      (inc),
    .cnt_o      (count_o),
    .wrap_o     (wrap)
  );

  lfc_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_rst_i),
    .wrap_i     (wrap),
    .rd_clr_i   (stat_rd_i),
    .mask_i     (irq_mask_i),
    .flag_o     (wrap_flag_o),
    .irq_o      (irq_o)
  );

  p_soft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> count_o == '0 && !wrap_flag_o);
  p_bad_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collision_i || !addr_match_i || !rx_overflow_i) && !soft_rst_i |=> $stable(count_o));
endmodule

// File: tb/tb_lost_frame_counter.sv
`timescale 1ns/1ps
module tb_lost_frame_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 0, rx_en = 0, fin = 0, match = 0, coll = 0, ovf = 0, rd = 0, mask = 0;
  logic [7:0] count;
  logic       flag, irq;

  always #2 clk = ~clk;

  lost_frame_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .rx_enable_i(rx_en),
    .frame_end_i(fin), .addr_match_i(match), .collision_i(coll),
    .rx_overflow_i(ovf), .stat_rd_i(rd), .irq_mask_i(mask),
    .count_o(count), .wrap_flag_o(flag), .irq_o(irq)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       flg;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic [7:0] m_cnt = 0;
  logic m_flag = 0, m_armed = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle and push the expected post-edge state
  task automatic step(input string tag, input logic s, input logic en, input logic f,
                      input logic am, input logic c, input logic o, input logic r, input logic mk);
    logic armed_now, ev, wr;
    exp_t e;
    @(negedge clk);
    soft_rst = s; rx_en = en; fin = f; match = am; coll = c; ovf = o; rd = r; mask = mk;
    armed_now = m_armed | en;
    ev = f & am & ~c & o & armed_now;
    if (s) begin
      m_cnt = 0; m_flag = 0; m_armed = 0;
    end else begin
      wr = ev && (m_cnt == 8'hff);
      m_cnt = m_cnt + {7'd0, ev};
      if (wr) m_flag = 1; else if (r) m_flag = 0;
      m_armed = armed_now;
    end
    e.cnt = m_cnt; e.flg = m_flag; e.irq = m_flag & ~mk; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic good(input string tag, input logic en);
    step(tag, 0, en, 1, 1, 0, 1, 0, 0);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " count"}, count, e.cnt);
        chk({e.tag, " flag"}, flag, e.flg);
        chk({e.tag, " irq"}, irq, e.irq);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    #1;
    chk("R1 reset count", count, 0);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset irq", irq, 0);
    #10 rst_n = 1'b1;
    // not yet armed
    for (int i = 0; i < 3; i++) good("R4 unarmed", 0);
    good("R4 first enable counts", 1);
    good("R2 armed sticky", 0);
    good("R2 count", 0);
    step("R3 no match", 0, 0, 1, 0, 0, 1, 0, 0);
    step("R3 collision", 0, 0, 1, 1, 1, 1, 0, 0);
    step("R3 no overflow", 0, 0, 1, 1, 0, 0, 0, 0);
    step("R3 no frame end", 0, 0, 0, 1, 0, 1, 0, 0);
    // run to the wrap
    while (m_cnt != 8'hff) good("R2 fill", 0);
    good("R5 wrap", 0);
    good("R5 continue", 0);
    step("R6 masked", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6 unmasked", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 read clear", 0, 0, 0, 0, 0, 0, 1, 0);
    while (m_cnt != 8'hff) good("R2 fill2", 0);
    step("R7 wrap beats read", 0, 0, 1, 1, 0, 1, 1, 0);
    step("R6 irq hold", 0, 0, 0, 0, 0, 0, 0, 0);
    good("R5 after wrap", 0);
    step("R8 soft reset", 1, 0, 0, 0, 0, 0, 0, 0);
    good("R8 unarmed after soft", 0);
    good("R8 rearm", 1);
    good("R2 after rearm", 0);
    while (exp_q.size() > 0) @(negedge clk);
    // hardware reset clears arm bit
    @(negedge clk);
    rst_n = 1'b0; fin = 0; rx_en = 0; rd = 0;
    #1;
    chk("R1 hw reset count", count, 0);
    chk("R1 hw reset flag", flag, 0);
    m_cnt = 0; m_flag = 0; m_armed = 0;
    @(negedge clk);
    rst_n = 1'b1;
    good("R4 unarmed after hw reset", 0);
    good("R4 enable again", 1);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule